// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block keeps two 64-bit performance counters. One counts clock cycles and the other counts retired instructions. Each counter can leave out the time or work spent in chosen privilege modes. Both counters share one mode tracker. On every change of privilege level or virtualization flag, the tracker makes each counter close the interval of the mode being left. The counter adds the events that interval collected to that mode's own accumulator, then notes the starting point for the mode being entered. Five modes are kept apart: machine, supervisor and user without virtualization, and supervisor and user with virtualization.

A configuration word per counter carries one inhibit flag per mode. The visible value is the sum of the accumulators whose flag is clear. When no flag is set, the visible value is the raw free-running count. Software can write a counter. A write records the written value together with the filtered value at that moment as a reference. Later reads return the filtered value minus the reference plus the written value. A 32-bit mode makes the low and high halves separately accessible. A per-counter freeze input holds the value that a read returns.

Top module: `pfc_counter_pair`

## Requirements
- R1: While reset is high, and in the first cycle after it, `csr_rdata_o` is zero. Reset clears all counts, snapshots, written values and references, and leaves the current mode at machine.
- R2: Channel 0 (`csr_sel_i`=0) counts one event every clock cycle. Channel 1 (`csr_sel_i`=1) counts one event in each cycle where `retire_i` is high. Counts wrap modulo 2^64.
- R3: Each event is charged to the mode shown on `priv_i`/`virt_i` in that same cycle. Priv 3 maps to machine whatever `virt_i` is. Priv 1 maps to supervisor, or to virtual supervisor when `virt_i`=1. Priv 0 maps to user, or to virtual user when `virt_i`=1. Priv 2 is reserved: the previous mode stays in force.
- R4: In each 64-bit config word, bit 62 inhibits machine, 61 supervisor, 60 user, 59 virtual supervisor and 58 virtual user. A set bit removes that mode's whole count from the filtered value. All other config bits have no effect.
- R5: When bits 62:58 of a channel's config are all zero, the filtered value is the raw total count of that channel.
- R6: A change of only the virtualization flag, including one while in machine mode, closes and reopens an interval without losing or duplicating any event.
- R7: With `rv32_mode_i`=0, a write stores `csr_wdata_i` and captures the current filtered value as a reference. A later read returns filtered − reference + written value, modulo 2^64.
- R8: With `rv32_mode_i`=1, `csr_hi_i` selects a 32-bit half. Each half keeps its own written value and reference. A high read returns bits 63:32 of the filtered value, adjusted by that half's own written value and reference. A low read returns bits 31:0, adjusted the same way by the low half's values. Bits 63:32 of `csr_rdata_o` are zero.
- R9: While `cnt_inh_i[ch]` is high, the filtered value seen by channel ch is frozen at its value in the last cycle before the input rose. Without writes, reads of that channel do not change. Counting continues underneath.
- R10: `csr_rdata_o` is registered. It shows the selected channel and half as computed from the state at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 2 reserved, 3 machine) |
| virt_i | input | 1 | Current virtualization flag |
| retire_i | input | 1 | One instruction retires this cycle |
| cfg_cyc_i | input | 64 | Filter config of the cycle channel |
| cfg_ins_i | input | 64 | Filter config of the instruction channel |
| cnt_inh_i | input | 2 | Per-channel freeze (bit 0 cycle, bit 1 instruction) |
| rv32_mode_i | input | 1 | Split 32-bit access mode |
| csr_sel_i | input | 1 | Channel select for read and write |
| csr_hi_i | input | 1 | Upper half select in 32-bit mode |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Registered read value |

## Verification
A table drives long runs in each of the five modes. It also covers the reserved priv value under both virtualization settings and machine mode with the virtualization flag set. Each run ends with a read under a different inhibit mask. A wrong mode mapping, a lost interval and a swapped inhibit bit each show up as a distinct wrong sum. Rapid toggling of only the virtualization flag tells apart a correct delta-before-snapshot order from one that drops or double-counts a cycle. Writes under 64-bit and split 32-bit access, with a wrap of the low half, separate the reference arithmetic of each half. A freeze with a write in the middle shows that the held value, and not the live one, becomes the reference.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int NMODE = 5;
  localparam int MIW   = 3;

  typedef logic [MIW-1:0] midx_t;

  localparam logic [1:0] PRIV_U   = 2'd0;
  localparam logic [1:0] PRIV_S   = 2'd1;
  localparam logic [1:0] PRIV_RSV = 2'd2;
  localparam logic [1:0] PRIV_M   = 2'd3;

  // accumulator slots; slot k is inhibited by config bit (top - k)
  localparam midx_t MI_M  = 3'd0;
  localparam midx_t MI_S  = 3'd1;
  localparam midx_t MI_U  = 3'd2;
  localparam midx_t MI_VS = 3'd3;
  localparam midx_t MI_VU = 3'd4;

  function automatic midx_t mode_slot(logic [1:0] priv, logic virt);
    midx_t r;
    case (priv)
      PRIV_M:  r = MI_M;
      PRIV_S:  r = virt ? MI_VS : MI_S;
      default: r = virt ? MI_VU : MI_U;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfc_mode_track.sv
module pfc_mode_track
  import pfc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output logic       sw_o,
  output midx_t      old_o,
  output midx_t      new_o
);

  logic [1:0] cur_priv_q;
  logic       cur_virt_q;
  logic       priv_ok;

  assign priv_ok = (priv_i != PRIV_RSV);
  assign sw_o    = priv_ok && ((priv_i != cur_priv_q) || (virt_i != cur_virt_q));
  assign old_o   = mode_slot(cur_priv_q, cur_virt_q);
  assign new_o   = mode_slot(priv_i, virt_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_priv_q <= PRIV_M;
      cur_virt_q <= 1'b0;
    end else if (sw_o) begin
      cur_priv_q <= priv_i;
      cur_virt_q <= virt_i;
    end
  end

endmodule

// File: rtl/pfc_accum.sv
module pfc_accum
  import pfc_pkg::*;
#(
  parameter int CW = 64,
  parameter int NM = NMODE
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          evt_i,
  input  logic          sw_i,
  input  midx_t         old_i,
  input  midx_t         new_i,
  input  logic [NM-1:0] inh_i,
  output logic [CW-1:0] filt_o
);

  logic [CW-1:0] base_q;
  logic [CW-1:0] term [NM];
  logic [CW-1:0] sum;

  always_ff @(posedge clk_i) begin
    if (rst_i) base_q <= '0;
    else if (evt_i) base_q <= base_q + CW'(1);
  end

  for (genvar m = 0; m < NM; m++) begin : g_slot
    logic [CW-1:0] snap_q;
    logic [CW-1:0] acc_q;
    logic [CW-1:0] live;

    // nonblocking: delta uses the old snapshot even if old == new slot
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        snap_q <= '0;
        acc_q  <= '0;
      end else if (sw_i) begin
        if (old_i == midx_t'(m)) acc_q  <= acc_q + (base_q - snap_q);
        if (new_i == midx_t'(m)) snap_q <= base_q;
      end
    end

    assign live    = (old_i == midx_t'(m)) ? (base_q - snap_q) : '0;
    assign term[m] = inh_i[m] ? '0 : (acc_q + live);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NM; k++) sum = sum + term[k];
  end

  assign filt_o = (|inh_i) ? sum : base_q;

endmodule

// File: rtl/pfc_csr_view.sv
module pfc_csr_view #(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] filt_i,
  input  logic          frz_i,
  input  logic          we_i,
  input  logic          hi_i,
  input  logic          rv32_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] view_o
);

  logic [CW-1:0] hold_q;
  logic [CW-1:0] wr_lo_q;
  logic [CW-1:0] ref_lo_q;
  logic [HW-1:0] wr_hi_q;
  logic [HW-1:0] ref_hi_q;
  logic [CW-1:0] eff;
  logic [HW-1:0] half_lo;
  logic [HW-1:0] half_hi;

  assign eff     = frz_i ? hold_q : filt_i;
  assign half_lo = eff[HW-1:0] - ref_lo_q[HW-1:0] + wr_lo_q[HW-1:0];
  assign half_hi = eff[CW-1:HW] - ref_hi_q + wr_hi_q;

  always_comb begin
    if (rv32_i) view_o = {{HW{1'b0}}, (hi_i ? half_hi : half_lo)};
    else        view_o = eff - ref_lo_q + wr_lo_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q   <= '0;
      wr_lo_q  <= '0;
      ref_lo_q <= '0;
      wr_hi_q  <= '0;
      ref_hi_q <= '0;
    end else begin
      if (!frz_i) hold_q <= filt_i;
      if (we_i) begin
        if (!rv32_i) begin
          wr_lo_q  <= wdata_i;
          ref_lo_q <= eff;
        end else if (hi_i) begin
          wr_hi_q  <= wdata_i[HW-1:0];
          ref_hi_q <= eff[CW-1:HW];
        end else begin
          wr_lo_q  <= CW'(wdata_i[HW-1:0]);
          ref_lo_q <= CW'(eff[HW-1:0]);
        end
      end
    end
  end

endmodule

// File: rtl/pfc_counter_pair.sv
module pfc_counter_pair
  import pfc_pkg::*;
#(
  parameter int CW    = 64,
  parameter int CFG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             retire_i,
  input  logic [CFG_W-1:0] cfg_cyc_i,
  input  logic [CFG_W-1:0] cfg_ins_i,
  input  logic [1:0]       cnt_inh_i,
  input  logic             rv32_mode_i,
  input  logic             csr_sel_i,
  input  logic             csr_hi_i,
  input  logic             csr_we_i,
  input  logic [CW-1:0]    csr_wdata_i,
  output logic [CW-1:0]    csr_rdata_o
);

  localparam int NCH    = 2;
  localparam int INH_HI = CFG_W - 2;
  localparam int INH_LO = INH_HI - NMODE + 1;

  logic  sw;
  midx_t old_slot;
  midx_t new_slot;
  logic [CW-1:0] view [NCH];
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_cyc_i[CFG_W-1], cfg_cyc_i[INH_LO-1:0],
                             cfg_ins_i[CFG_W-1], cfg_ins_i[INH_LO-1:0]};

  pfc_mode_track u_track (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .priv_i (priv_i),
    .virt_i (virt_i),
    .sw_o   (sw),
    .old_o  (old_slot),
    .new_o  (new_slot)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CFG_W-1:0] cfg;
    logic [NMODE-1:0] inh;
    logic             evt;
    logic [CW-1:0]    filt;

    assign cfg = (ch == 0) ? cfg_cyc_i : cfg_ins_i;
    assign evt = (ch == 0) ? 1'b1 : retire_i;

    for (genvar m = 0; m < NMODE; m++) begin : g_map
      assign inh[m] = cfg[INH_HI-m];
    end

    pfc_accum #(.CW(CW), .NM(NMODE)) u_acc (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .evt_i  (evt),
      .sw_i   (sw),
      .old_i  (old_slot),
      .new_i  (new_slot),
      .inh_i  (inh),
      .filt_o (filt)
    );

    pfc_csr_view #(.CW(CW)) u_view (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .filt_i  (filt),
      .frz_i   (cnt_inh_i[ch]),
      .we_i    (csr_we_i && (csr_sel_i == ch[0])),
      .hi_i    (csr_hi_i),
      .rv32_i  (rv32_mode_i),
      .wdata_i (csr_wdata_i),
      .view_o  (view[ch])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) csr_rdata_o <= '0;
    else       csr_rdata_o <= view[csr_sel_i];
  end

endmodule

// File: rtl/pfc_counter_pair_chk.sv
module pfc_counter_pair_chk #(
  parameter int CW = 64
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          retire_i,
  input logic [1:0]    cnt_inh_i,
  input logic          rv32_mode_i,
  input logic          csr_sel_i,
  input logic          csr_hi_i,
  input logic          csr_we_i,
  input logic [4:0]    cyc_inh_i,
  input logic [4:0]    ins_inh_i,
  input logic [CW-1:0] csr_rdata_o
);

  logic [1:0] age_q;
  logic past_ok, c_cyc, c_ins, c_all, c_frz;

  always_ff @(posedge clk_i) begin
    if (rst_i) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign past_ok = (age_q == 2'd3);
  assign c_cyc = !csr_sel_i && !cnt_inh_i[0] && !rv32_mode_i && (cyc_inh_i == '0) && !csr_we_i;
  assign c_ins = csr_sel_i && !cnt_inh_i[1] && !rv32_mode_i && (ins_inh_i == '0) && !csr_we_i;
  assign c_all = !csr_sel_i && !cnt_inh_i[0] && !rv32_mode_i && (cyc_inh_i == 5'h1F) && !csr_we_i;
  assign c_frz = cnt_inh_i[csr_sel_i] && !csr_we_i;

  assert_rv32_upper_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && $past(rv32_mode_i)) |-> (csr_rdata_o[CW-1:CW/2] == '0));

  assert_cycle_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && c_cyc && $past(c_cyc)) |=> (csr_rdata_o == $past(csr_rdata_o) + CW'(1)));

  assert_retire_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && c_ins && $past(c_ins)) |=>
      (csr_rdata_o == $past(csr_rdata_o) + CW'($past(retire_i, 2))));

  assert_all_inhibited_flat_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && c_all && $past(c_all)) |=> $stable(csr_rdata_o));

  assert_freeze_holds_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && c_frz && $past(c_frz) && $stable(csr_sel_i) && $stable(csr_hi_i)
     && $stable(rv32_mode_i)) |=> $stable(csr_rdata_o));

endmodule

bind pfc_counter_pair pfc_counter_pair_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .retire_i    (retire_i),
  .cnt_inh_i   (cnt_inh_i),
  .rv32_mode_i (rv32_mode_i),
  .csr_sel_i   (csr_sel_i),
  .csr_hi_i    (csr_hi_i),
  .csr_we_i    (csr_we_i),
  .cyc_inh_i   (cfg_cyc_i[62:58]),
  .ins_inh_i   (cfg_ins_i[62:58]),
  .csr_rdata_o (csr_rdata_o)
);

// File: tb/test_pfc_counter_pair.sv
`timescale 1ns/1ps
module test_pfc_counter_pair;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic        retire = 1'b0;
  logic [63:0] cfg_cyc = '0;
  logic [63:0] cfg_ins = '0;
  logic [1:0]  cnt_inh = '0;
  logic        rv32 = 1'b0;
  logic        sel = 1'b0;
  logic        hi = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pfc_counter_pair i_pfc_counter_pair (
    .clk_i(clk), .rst_i(rst), .priv_i(priv), .virt_i(virt), .retire_i(retire),
    .cfg_cyc_i(cfg_cyc), .cfg_ins_i(cfg_ins), .cnt_inh_i(cnt_inh),
    .rv32_mode_i(rv32), .csr_sel_i(sel), .csr_hi_i(hi), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt [2][5];
  logic [63:0] m_wr  [2][2];
  logic [63:0] m_ref [2][2];
  logic [63:0] m_hold [2];
  int          m_cur = 0;
  logic [63:0] exp_rd, got;

  // priv/virt to slot: 0 M, 1 S, 2 U, 3 VS, 4 VU (slot k inhibited by cfg bit 62-k)
  function automatic int slot_of(logic [1:0] p, logic v);
    if (p == 2'd3) return 0;
    if (p == 2'd1) return v ? 3 : 1;
    return v ? 4 : 2;
  endfunction

  function automatic logic [63:0] m_filt(int ch);
    logic [63:0] c = (ch == 0) ? cfg_cyc : cfg_ins;
    logic [63:0] s = '0;
    for (int k = 0; k < 5; k++)
      if (c[62:58] == '0 || !c[62-k]) s = s + m_cnt[ch][k];
    return s;
  endfunction

  function automatic logic [63:0] m_eff(int ch);
    return cnt_inh[ch] ? m_hold[ch] : m_filt(ch);
  endfunction

  function automatic logic [63:0] m_view(int ch);
    logic [63:0] e = m_eff(ch);
    logic [31:0] h;
    if (!rv32) return e - m_ref[ch][0] + m_wr[ch][0];
    if (hi) h = e[63:32] - m_ref[ch][1][31:0] + m_wr[ch][1][31:0];
    else    h = e[31:0]  - m_ref[ch][0][31:0] + m_wr[ch][0][31:0];
    return {32'd0, h};
  endfunction

  task automatic tick();
    logic [63:0] e [2];
    logic [63:0] f [2];
    int ni;
    exp_rd = m_view(int'(sel));
    for (int ch = 0; ch < 2; ch++) begin
      e[ch] = m_eff(ch);
      f[ch] = m_filt(ch);
    end
    ni = (priv == 2'd2) ? m_cur : slot_of(priv, virt);
    @(posedge clk);
    m_cur = ni;
    m_cnt[0][ni] = m_cnt[0][ni] + 64'd1;
    if (retire) m_cnt[1][ni] = m_cnt[1][ni] + 64'd1;
    for (int ch = 0; ch < 2; ch++) begin
      if (we && int'(sel) == ch) begin
        if (!rv32) begin
          m_wr[ch][0] = wdata; m_ref[ch][0] = e[ch];
        end else if (hi) begin
          m_wr[ch][1] = {32'd0, wdata[31:0]}; m_ref[ch][1] = {32'd0, e[ch][63:32]};
        end else begin
          m_wr[ch][0] = {32'd0, wdata[31:0]}; m_ref[ch][0] = {32'd0, e[ch][31:0]};
        end
      end
      if (!cnt_inh[ch]) m_hold[ch] = f[ch];
    end
    #1 got = rdata;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {priv[2], virt, retire, sel, mask[5] (M,S,U,VS,VU), len[8]}
  localparam logic [17:0] VEC [12] = '{
    {2'd3, 1'b0, 1'b1, 1'b0, 5'b00000, 8'd5},
    {2'd1, 1'b0, 1'b1, 1'b1, 5'b00000, 8'd7},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'b10000, 8'd6},
    {2'd1, 1'b1, 1'b1, 1'b1, 5'b00001, 8'd4},
    {2'd0, 1'b1, 1'b1, 1'b0, 5'b00010, 8'd9},
    {2'd2, 1'b0, 1'b1, 1'b1, 5'b01000, 8'd3},
    {2'd3, 1'b1, 1'b1, 1'b0, 5'b00100, 8'd4},
    {2'd3, 1'b0, 1'b0, 1'b1, 5'b11110, 8'd5},
    {2'd0, 1'b0, 1'b1, 1'b0, 5'b01111, 8'd2},
    {2'd1, 1'b0, 1'b1, 1'b1, 5'b10101, 8'd1},
    {2'd0, 1'b1, 1'b1, 1'b0, 5'b11111, 8'd3},
    {2'd2, 1'b1, 1'b0, 1'b1, 5'b00000, 8'd6}
  };

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v1;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 5; k++) m_cnt[c][k] = '0;
      m_wr[c][0] = '0; m_wr[c][1] = '0; m_ref[c][0] = '0; m_ref[c][1] = '0;
      m_hold[c] = '0;
    end
    repeat (3) @(posedge clk);
    #1 chk("R1 rdata in reset", rdata, 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 R10 first read after reset", got, 64'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 12; i++) begin
      priv = VEC[i][17:16]; virt = VEC[i][15]; retire = VEC[i][14];
      sel = VEC[i][13];
      cfg_cyc = {1'b0, VEC[i][12:8], 58'hFF};
      cfg_ins = {1'b0, VEC[i][12:8], 58'hFF};
      for (int n = 0; n < int'(VEC[i][7:0]); n++) tick();
      chk($sformatf("R2 R3 R4 R5 table row %0d", i), got, exp_rd);
    end

    // R6: toggle virt only, in machine with only machine visible
    priv = 2'd3; sel = 1'b0; cfg_cyc = {1'b0, 5'b01111, 58'd0};
    tick(); tick(); v1 = got;
    for (int n = 0; n < 6; n++) begin virt = ~virt; tick(); end
    chk("R6 machine virt toggle", got, v1 + 64'd6);
    chk("R6 model", got, exp_rd);
    // R6: toggle virt in supervisor, only VS visible
    priv = 2'd1; cfg_cyc = {1'b0, 5'b11101, 58'd0};
    for (int n = 0; n < 10; n++) begin virt = ~virt; tick(); end
    chk("R6 supervisor virt toggle", got, exp_rd);

    // R7: 64-bit write
    cfg_cyc = '0; virt = 1'b0;
    we = 1'b1; wdata = 64'h0000_0001_0000_0000; tick();
    we = 1'b0; tick();
    chk("R7 read right after write", got, 64'h0000_0001_0000_0001);
    repeat (4) tick();
    chk("R7 read later", got, exp_rd);

    // R8: split halves on instruction channel, low half wraps
    rv32 = 1'b1; sel = 1'b1; hi = 1'b0; retire = 1'b1; cfg_ins = '0;
    we = 1'b1; wdata = 64'hDEAD_0000_FFFF_FFF0; tick();
    we = 1'b0;
    repeat (20) tick();
    chk("R8 low half wrap", got, exp_rd);
    hi = 1'b1; tick();
    chk("R8 high half", got, exp_rd);
    we = 1'b1; wdata = 64'h0000_0000_0000_0007; tick();
    we = 1'b0; tick();
    chk("R8 high half write", got, 64'd7);
    hi = 1'b0; tick();
    chk("R8 low half unaffected", got, exp_rd);
    rv32 = 1'b0; hi = 1'b0;

    // R9: freeze cycle channel, write while frozen, release
    sel = 1'b0; cnt_inh = 2'b01;
    tick(); tick(); v1 = got;
    repeat (5) tick();
    chk("R9 frozen value stable", got, v1);
    chk("R9 frozen model", got, exp_rd);
    we = 1'b1; wdata = 64'd100; tick();
    we = 1'b0; tick();
    chk("R9 R7 write while frozen", got, 64'd100);
    cnt_inh = 2'b00; tick(); tick();
    chk("R9 released counts again", got, exp_rd);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule